// File: doc/BRIEF.md
# AC-link Output Frame Assembler

This block builds each outgoing serial frame of an audio/modem codec link and shifts it out on the data-out line in step with the bit clock. A rising edge on the frame sync input starts a frame. The frame holds 256 bit times: a 16-bit tag slot, then twelve 20-bit slots, sent MSB first. The tag marks which slots hold valid data. The block fills slots 1 and 2 with the pending codec register command. Slot 5 carries the modem DAC sample, justified to the MSB at the selected resolution. Slot 12 carries the codec GPIO value. Every other slot goes out as zeros.

Register traffic arrives as one-cycle requests. Each request is held as a single pending command and is sent once, on the next frame. A write to codec register 0x54 also stores the GPIO value. From that write on, slot 12 is valid in every frame and repeats the last value written. Either reset clears this state. The frame is latched whole when it starts, so inputs that change later cannot split a slot.

Top module: `aclink_tx_framer`

## Requirements
- R1: The frame loads on the clock edge where `sync_i` is high and was low on the edge before. Tag bit 15 appears on `sdata_o` after that edge, and the 256 frame bits follow MSB first, one per clock. When the frame ends, and from reset until the first sync, `sdata_o` stays 0.
- R2: Tag bit 14 down to bit 3 are the valid flags for slots 1 to 12. Tag bits 2..0 are 0. Tag bit 15 is 1 when any slot flag is set.
- R3: For a pending command, slot 1 is valid. Its bit 19 is 1 for a read and 0 for a write, bits 18:12 hold the 7-bit address, and bits 11:0 are 0. Slot 2 is valid only for a write and holds the 16-bit data in bits 19:4, with bits 3:0 at 0. A slot that is not valid is all zeros.
- R4: A command goes out in exactly one frame. Later frames show slots 1 and 2 as invalid and zero until a new request arrives.
- R5: A request that arrives while an earlier one is still unsent replaces it.
- R6: When `dac_valid_i` is set, slot 5 is valid and carries the sample MSB-justified. `dac_res_i` selects the width: 0 keeps 16 bits, 1 keeps 18, and 2 or 3 keep 20. The trailing bits are 0. When `dac_valid_i` is clear, slot 5 is invalid and zero.
- R7: Slots 3, 4 and 6 to 11 are always zero, and their tag flags are 0.
- R8: After `rst_ni`, slot 12 is invalid and zero until a write to address 0x54.
- R9: After a write to 0x54, the next frame carries the data in slot 12 bits 19:4 and marks slot 12 valid. The same write is also sent on slots 1 and 2.
- R10: Once set, slot 12 stays valid in every later frame and repeats the last value written to 0x54. Writes to other addresses do not change it.
- R11: A `cold_rst_i` pulse clears slot 12 validity, the stored GPIO value and any unsent command.
- R12: A frame carries the input and command state that held at its load edge. Changes during the frame appear in the next frame.
- R13: A read of address 0x54 leaves the slot 12 value and validity unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; the output changes on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| cold_rst_i | input | 1 | Synchronous link cold reset pulse |
| sync_i | input | 1 | Frame sync; a rising edge starts a frame |
| cmd_req_i | input | 1 | One-cycle codec register command request |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | 7 | Codec register address |
| cmd_data_i | input | 16 | Write data |
| dac_valid_i | input | 1 | Modem DAC sample present |
| dac_res_i | input | 2 | DAC resolution select |
| dac_data_i | input | 20 | Modem DAC sample, MSB-aligned |
| sdata_o | output | 1 | Serial frame data out |

## Verification
Directed frames walk slot 12 through its whole life: invalid after reset, set by a write to 0x54, kept through a quiet frame and through a read of 0x54, replaced by a later write, and cleared by a cold reset. These frames separate a valid bit that persists from one that is sent once. Two requests inside one frame check that the newer one wins, and an idle gap checks that the line returns to zero. Random frames then mix addresses, read and write, all four resolution codes and sample values, with occasional cold resets. All inputs change in the middle of a frame, so a design that reads them live instead of latching them at the load edge gives mismatched slots.

// File: rtl/aclink_tx_pkg.sv
package aclink_tx_pkg;
  localparam int TAG_W   = 16;
  localparam int SLOT_W  = 20;
  localparam int N_SLOTS = 12;
  localparam int FRAME_W = TAG_W + SLOT_W * N_SLOTS;

  localparam int SLOT_CMD_ADDR = 1;
  localparam int SLOT_CMD_DATA = 2;
  localparam int SLOT_MODEM    = 5;
  localparam int SLOT_GPIO     = 12;

  typedef enum logic [1:0] {
    RES_16  = 2'd0,
    RES_18  = 2'd1,
    RES_20  = 2'd2,
    RES_20X = 2'd3
  } dac_res_e;

  function automatic int res_keep_bits(input logic [1:0] res);
    case (res)
      RES_16:  return 16;
      RES_18:  return 18;
      default: return 20;
    endcase
  endfunction
endpackage

// File: rtl/aclink_cmd_ctl.sv
module aclink_cmd_ctl #(
  parameter int              ADDR_W    = 7,
  parameter int              DATA_W    = 16,
  parameter logic [ADDR_W-1:0] GPIO_ADDR = 7'h54
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cold_rst_i,
  input  logic              frame_start_i,
  input  logic              req_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pend_o,
  output logic              pend_write_o,
  output logic [ADDR_W-1:0] pend_addr_o,
  output logic [DATA_W-1:0] pend_data_o,
  output logic              gpio_vld_o,
  output logic [DATA_W-1:0] gpio_o
);
  logic gpio_hit;
  assign gpio_hit = req_i && write_i && (addr_i == GPIO_ADDR);

  // pending command: a new request overrides; the load edge consumes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o       <= 1'b0;
      pend_write_o <= 1'b0;
      pend_addr_o  <= '0;
      pend_data_o  <= '0;
    end else if (cold_rst_i) begin
      pend_o       <= 1'b0;
      pend_write_o <= 1'b0;
      pend_addr_o  <= '0;
      pend_data_o  <= '0;
    end else if (req_i) begin
      pend_o       <= 1'b1;
      pend_write_o <= write_i;
      pend_addr_o  <= addr_i;
      pend_data_o  <= data_i;
    end else if (frame_start_i) begin
      pend_o       <= 1'b0;
    end
  end

  // slot 12 shadow: sticky valid until either reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gpio_vld_o <= 1'b0;
      gpio_o     <= '0;
    end else if (cold_rst_i) begin
      gpio_vld_o <= 1'b0;
      gpio_o     <= '0;
    end else if (gpio_hit) begin
      gpio_vld_o <= 1'b1;
      gpio_o     <= data_i;
    end
  end

  a_r4_sent_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && pend_o && !req_i && !cold_rst_i) |=> !pend_o);

  a_r10_gpio_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpio_vld_o && !cold_rst_i) |=> gpio_vld_o);

  a_r11_cold_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_rst_i |=> (!gpio_vld_o && !pend_o && gpio_o == '0));

  a_r13_read_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !write_i && !cold_rst_i) |=> $stable(gpio_o) && $stable(gpio_vld_o));
endmodule

// File: rtl/aclink_slot_pack.sv
module aclink_slot_pack
  import aclink_tx_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int DAC_W  = 20
) (
  input  logic               pend_i,
  input  logic               pend_write_i,
  input  logic [ADDR_W-1:0]  pend_addr_i,
  input  logic [DATA_W-1:0]  pend_data_i,
  input  logic               dac_valid_i,
  input  logic [1:0]         dac_res_i,
  input  logic [DAC_W-1:0]   dac_data_i,
  input  logic               gpio_vld_i,
  input  logic [DATA_W-1:0]  gpio_i,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int PAD_W = TAG_W - 1 - N_SLOTS;

  logic [SLOT_W-1:0] dac_just;
  logic [SLOT_W-1:0] dac_mask;
  logic [SLOT_W-1:0] sd [1:N_SLOTS];
  logic [N_SLOTS:1]  sv;

  generate
    if (DAC_W == SLOT_W) begin : g_dac_full
      assign dac_just = dac_data_i;
    end else begin : g_dac_pad
      assign dac_just = {dac_data_i, {(SLOT_W - DAC_W){1'b0}}};
    end
  endgenerate

  always_comb begin
    dac_mask = {SLOT_W{1'b1}} << (SLOT_W - res_keep_bits(dac_res_i));
  end

  always_comb begin
    for (int k = 1; k <= N_SLOTS; k++) begin
      sd[k] = '0;
      sv[k] = 1'b0;
    end
    sv[SLOT_CMD_ADDR] = pend_i;
    if (pend_i)
      sd[SLOT_CMD_ADDR] = SLOT_W'({!pend_write_i, pend_addr_i}) << (SLOT_W - 1 - ADDR_W);
    sv[SLOT_CMD_DATA] = pend_i && pend_write_i;
    if (pend_i && pend_write_i)
      sd[SLOT_CMD_DATA] = SLOT_W'(pend_data_i) << (SLOT_W - DATA_W);
    sv[SLOT_MODEM] = dac_valid_i;
    if (dac_valid_i)
      sd[SLOT_MODEM] = dac_just & dac_mask;
    sv[SLOT_GPIO] = gpio_vld_i;
    if (gpio_vld_i)
      sd[SLOT_GPIO] = SLOT_W'(gpio_i) << (SLOT_W - DATA_W);
  end

  always_comb begin
    frame_o = '0;
    frame_o[FRAME_W-1] = |sv;
    for (int k = 1; k <= N_SLOTS; k++) begin
      frame_o[FRAME_W-1-k] = sv[k];
      frame_o[FRAME_W-TAG_W-1-(k-1)*SLOT_W -: SLOT_W] = sd[k];
    end
    frame_o[FRAME_W-TAG_W +: PAD_W] = '0;
  end
endmodule

// File: rtl/aclink_shifter.sv
module aclink_shifter
  import aclink_tx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               start_o,
  output logic               sdata_o
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam int PAD_W = TAG_W - 1 - N_SLOTS;

  logic               sync_q;
  logic               busy_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sh_q;

  assign start_o = sync_i && !sync_q;
  assign sdata_o = sh_q[FRAME_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      sync_q <= sync_i;
      if (start_o) begin
        sh_q   <= frame_i;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(FRAME_W - 1)) busy_q <= 1'b0;
      end
    end
  end

  a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sdata_o);

  a_r1_frame_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_o && cnt_q == CNT_W'(FRAME_W - 1)) |=> !busy_q);

  a_r2_frame_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (sh_q[FRAME_W-1] == (|sh_q[FRAME_W-2 -: N_SLOTS])));

  a_r2_tag_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (sh_q[FRAME_W-TAG_W +: PAD_W] == '0));
endmodule

// File: rtl/aclink_tx_framer.sv
module aclink_tx_framer
  import aclink_tx_pkg::*;
#(
  parameter int                ADDR_W    = 7,
  parameter int                DATA_W    = 16,
  parameter int                DAC_W     = 20,
  parameter logic [ADDR_W-1:0] GPIO_ADDR = 7'h54
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cold_rst_i,
  input  logic              sync_i,
  input  logic              cmd_req_i,
  input  logic              cmd_write_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              dac_valid_i,
  input  logic [1:0]        dac_res_i,
  input  logic [DAC_W-1:0]  dac_data_i,
  output logic              sdata_o
);
  logic               start;
  logic               pend, pend_write, gpio_vld;
  logic [ADDR_W-1:0]  pend_addr;
  logic [DATA_W-1:0]  pend_data, gpio;
  logic [FRAME_W-1:0] frame;

  aclink_cmd_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GPIO_ADDR(GPIO_ADDR)
  ) u_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .cold_rst_i(cold_rst_i),
    .frame_start_i(start), .req_i(cmd_req_i), .write_i(cmd_write_i),
    .addr_i(cmd_addr_i), .data_i(cmd_data_i),
    .pend_o(pend), .pend_write_o(pend_write), .pend_addr_o(pend_addr),
    .pend_data_o(pend_data), .gpio_vld_o(gpio_vld), .gpio_o(gpio)
  );

  aclink_slot_pack #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DAC_W(DAC_W)
  ) u_pack (
    .pend_i(pend), .pend_write_i(pend_write), .pend_addr_i(pend_addr),
    .pend_data_i(pend_data), .dac_valid_i(dac_valid_i), .dac_res_i(dac_res_i),
    .dac_data_i(dac_data_i), .gpio_vld_i(gpio_vld), .gpio_i(gpio),
    .frame_o(frame)
  );

  aclink_shifter u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .frame_i(frame),
    .start_o(start), .sdata_o(sdata_o)
  );
endmodule

// File: tb/sim_aclink_tx_framer.sv
module sim_aclink_tx_framer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cold_rst_i = 1'b0;
  logic        sync_i = 1'b0;
  logic        cmd_req_i = 1'b0;
  logic        cmd_write_i = 1'b0;
  logic [6:0]  cmd_addr_i = '0;
  logic [15:0] cmd_data_i = '0;
  logic        dac_valid_i = 1'b0;
  logic [1:0]  dac_res_i = '0;
  logic [19:0] dac_data_i = '0;
  logic        sdata_o;

  int n_chk = 0;
  int n_fail = 0;

  // reference state, updated by the bench as it drives stimulus
  bit          m_pend, m_pw, m_gv;
  logic [6:0]  m_pa;
  logic [15:0] m_pd, m_g;
  bit          nx_w, nx2_w;
  logic [6:0]  nx_a, nx2_a;
  logic [15:0] nx_d, nx2_d;

  always #2 clk_i = ~clk_i;

  aclink_tx_framer u0 (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h exp %h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_slot5(input bit v, input logic [1:0] r, input logic [19:0] d);
    if (!v) return '0;
    case (r)
      2'd0:    return d & 20'hFFFF0;
      2'd1:    return d & 20'hFFFFC;
      default: return d;
    endcase
  endfunction

  function automatic logic [19:0] slot_of(input logic [255:0] f, input int k);
    return f[239-20*(k-1) -: 20];
  endfunction

  task automatic model_req(input bit w, input logic [6:0] a, input logic [15:0] d);
    m_pend = 1; m_pw = w; m_pa = a; m_pd = d;
    if (w && a == 7'h54) begin m_gv = 1; m_g = d; end
  endtask

  task automatic do_frame(input bit a_cmd, input bit a_cmd2, input bit a_cold,
                          input bit a_dv, input logic [1:0] a_res, input logic [19:0] a_dac);
    logic [255:0] got;
    logic [15:0]  e_tag;
    logic [19:0]  e1, e2, e5, e12;
    bit           e_pend, e_pw, e_gv, e_dv;
    e_pend = m_pend; e_pw = m_pw; e_gv = m_gv; e_dv = dac_valid_i;
    e1  = m_pend ? {~m_pw, m_pa, 12'h000} : 20'h0;
    e2  = (m_pend && m_pw) ? {m_pd, 4'h0} : 20'h0;
    e5  = exp_slot5(dac_valid_i, dac_res_i, dac_data_i);
    e12 = m_gv ? {m_g, 4'h0} : 20'h0;
    e_tag = '0;
    e_tag[14] = e_pend; e_tag[13] = e_pend && e_pw; e_tag[10] = e_dv; e_tag[3] = e_gv;
    e_tag[15] = |e_tag[14:3];
    m_pend = 0;
    sync_i = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk_i);
      got[255-i] = sdata_o;
      if (i == 15) sync_i = 1'b0;
      if (i == 90 && a_cold) begin
        cold_rst_i = 1'b1; m_pend = 0; m_gv = 0; m_g = '0;
      end
      if (i == 91) cold_rst_i = 1'b0;
      if (i == 100) begin
        dac_valid_i = a_dv; dac_res_i = a_res; dac_data_i = a_dac;
        if (a_cmd) begin
          cmd_req_i = 1'b1; cmd_write_i = nx_w; cmd_addr_i = nx_a; cmd_data_i = nx_d;
          model_req(nx_w, nx_a, nx_d);
        end
      end
      if (i == 101) begin
        cmd_req_i = 1'b0;
        if (a_cmd2) begin
          cmd_req_i = 1'b1; cmd_write_i = nx2_w; cmd_addr_i = nx2_a; cmd_data_i = nx2_d;
          model_req(nx2_w, nx2_a, nx2_d);
        end
      end
      if (i == 102) cmd_req_i = 1'b0;
    end
    // R1 R2: tag slot; R12: every field reflects load-edge state
    check("R2", "tag", 32'(got[255:240]), 32'(e_tag));
    check("R3/R4/R5", "slot1", 32'(slot_of(got, 1)), 32'(e1));
    check("R3/R4", "slot2", 32'(slot_of(got, 2)), 32'(e2));
    check("R6/R12", "slot5", 32'(slot_of(got, 5)), 32'(e5));
    check("R8/R9/R10/R11/R12/R13", "slot12", 32'(slot_of(got, 12)), 32'(e12));
    check("R7", "zero slots",
          32'(slot_of(got,3) | slot_of(got,4) | slot_of(got,6) | slot_of(got,7) |
              slot_of(got,8) | slot_of(got,9) | slot_of(got,10) | slot_of(got,11)), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit any_hi;
    void'($urandom(32'd1729));
    m_pend = 0; m_pw = 0; m_gv = 0; m_pa = '0; m_pd = '0; m_g = '0;
    repeat (3) @(negedge clk_i);
    check("R1", "sdata in reset", 32'(sdata_o), 32'h0);
    rst_ni = 1'b1;
    dac_valid_i = 1'b1; dac_res_i = 2'd0; dac_data_i = 20'hABCDE;
    repeat (5) @(negedge clk_i);
    check("R1", "sdata before sync", 32'(sdata_o), 32'h0);

    // R8: slot 12 invalid out of reset; request write of 0x54 mid-frame
    nx_w = 1; nx_a = 7'h54; nx_d = 16'h1234;
    do_frame(1, 0, 0, 1, 2'd1, 20'h13579);
    // R9: write visible on slots 1, 2 and 12
    do_frame(0, 0, 0, 1, 2'd2, 20'hFEDCB);
    // R4, R10: command gone, slot 12 persists; issue read of 0x54 (R13)
    nx_w = 0; nx_a = 7'h54; nx_d = 16'hDEAD;
    do_frame(1, 0, 0, 1, 2'd3, 20'h2468A);
    // R5: two requests in one frame, second wins
    nx_w = 1; nx_a = 7'h02; nx_d = 16'h5555;
    nx2_w = 1; nx2_a = 7'h54; nx2_d = 16'h0F0F;
    do_frame(1, 1, 0, 0, 2'd0, 20'h11111);
    // R11: cold reset mid-frame
    do_frame(0, 0, 1, 1, 2'd0, 20'hFFFFF);
    // R10: write elsewhere leaves slot 12 cleared/unchanged
    nx_w = 1; nx_a = 7'h10; nx_d = 16'h4321;
    do_frame(1, 0, 0, 1, 2'd1, 20'hFFFFF);
    do_frame(0, 0, 0, 1, 2'd2, 20'h0);

    // R1: line idles low after the frame
    any_hi = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (sdata_o) any_hi = 1;
    end
    check("R1", "idle after frame", 32'(any_hi), 32'h0);

    for (int f = 0; f < 50; f++) begin
      bit c1, c2, cr;
      c1 = ($urandom % 3) != 0;
      c2 = c1 && (($urandom % 4) == 0);
      cr = ($urandom % 12) == 0;
      nx_w  = $urandom % 2;
      nx_a  = ($urandom % 2) ? 7'h54 : 7'($urandom);
      nx_d  = 16'($urandom);
      nx2_w = $urandom % 2;
      nx2_a = ($urandom % 2) ? 7'h54 : 7'($urandom);
      nx2_d = 16'($urandom);
      do_frame(c1, c2, cr, 1'($urandom), 2'($urandom), 20'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule